// File: doc/BRIEF.md
# Synchronous Serial Shift Engine

This block moves parallel words over a three-wire clocked serial link: a serial clock it generates itself, a data output and a data input. Because every party sees the same clock, a frame is nothing but its data bits, with no start, stop or parity bit. A frame holds 4 to 16 bits. The bits can go out in either order, and each data line can be inverted on its own.

The serial clock comes from the input clock through a divider value. That value has a 13-bit integer part and a 2-bit fraction. The average bit rate is f_clk / (2 × (1 + divider)), where the divider counts in quarter steps. A transmit word is offered on a valid/ready handshake. The frame length, the bit order and both inversions are captured when the word is accepted. Received words appear on a parallel output together with a one-cycle strobe. A loopback option feeds the serial output back into the receiver.

Top module: `sync_shift_engine`

## Requirements
- R1: A frame carries exactly the configured number of data bits: one rising serial clock edge per bit, and no start, stop or parity bit.
- R2: The frame length `nbits_i` is honoured from 4 to 16. Values below 4 are treated as 4 and values above 16 as 16.
- R3: With `msb_first_i` = 0, bit 0 of the word goes out first. With 1, bit (length-1) goes out first. The receiver puts each sampled bit back at the position it was sent from.
- R4: With `tx_inv_i` = 1 the data line carries the complement of each bit. When no frame is running, `sdo_o` rests at the level of `tx_inv_i`.
- R5: With `rx_inv_i` = 1 each sampled bit is complemented before it is stored.
- R6: Let the integer part of `div_i` be `div_i[14:2]` (I) and the fraction be `div_i[1:0]` (F). Each serial clock half-period lasts I+1 input clocks, plus one when a 2-bit fraction accumulator, cleared at frame start, carries. A frame of n bits therefore keeps `tx_ready_o` low for 2n(I+1) + floor(2n·F/4) cycles.
- R7: `sdo_o` changes only at frame start and on falling serial clock edges. The input is sampled on rising edges, so `sdo_o` is steady while `sclk_o` is high.
- R8: `sclk_o` is low whenever no frame runs. `tx_ready_o` is high exactly when idle, and a word is taken in the cycle where `tx_valid_i` and `tx_ready_o` are both high.
- R9: `rx_valid_o` pulses for one cycle after the last bit of a frame is sampled, and `rx_data_o` bits at or above the frame length read zero.
- R10: With `loopback_i` = 1 the receiver samples `sdo_o` instead of `sdi_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 15 | Divider: integer in [14:2], quarter steps in [1:0] |
| nbits_i | input | 5 | Data bits per frame (clamped to 4..16) |
| msb_first_i | input | 1 | Send and rebuild most significant bit first |
| tx_inv_i | input | 1 | Invert outgoing data line |
| rx_inv_i | input | 1 | Invert incoming data line |
| loopback_i | input | 1 | Route serial output into the receiver |
| tx_data_i | input | 16 | Transmit word |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Engine idle, word will be taken |
| rx_data_o | output | 16 | Received word |
| rx_valid_o | output | 1 | One-cycle strobe for a received word |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
On every cycle, the assertions check the following: the serial clock stays low while idle, data holds steady while the serial clock is high, an accepted word drops ready on the next cycle, half-periods are never shorter than the integer divider allows, the receive strobe is a single cycle, and unused receive bits are zero. Other behaviours can only be shown by the bench's scenarios: the exact frame duration with fractional stretching, the order of bits on the wire, the effect of each inversion, length clamping, and the rebuilt word through loopback or through a constant external input.

// File: rtl/sse_pkg.sv
package sse_pkg;
  localparam int unsigned SSE_MIN_BITS = 4;

  typedef struct packed {
    logic msb_first;
    logic tx_inv;
    logic rx_inv;
  } sse_mode_t;
endpackage

// File: rtl/sse_clkgen.sv
module sse_clkgen #(
  parameter int INT_W  = 13,
  parameter int FRAC_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    run_i,
  input  logic [INT_W+FRAC_W-1:0] div_i,
  output logic                    tick_o
);
  localparam int CNT_W = INT_W + 1;

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q, acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FRAC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, frac_q};
  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q  <= '0;
      frac_q <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      int_q  <= div_i[INT_W+FRAC_W-1:FRAC_W];
      frac_q <= div_i[FRAC_W-1:0];
      acc_q  <= div_i[FRAC_W-1:0];  // first half: 0 + frac never carries
      cnt_q  <= {1'b0, div_i[INT_W+FRAC_W-1:FRAC_W]};
    end else if (tick_o) begin
      acc_q  <= sum[FRAC_W-1:0];
      cnt_q  <= {1'b0, int_q} + CNT_W'(sum[FRAC_W]);
    end else if (run_i) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  p_tick_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && int_q != '0) |=> !tick_o);
endmodule

// File: rtl/sse_tx.sv
module sse_tx #(
  parameter int MAX_BITS = 16,
  parameter int IDX_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [IDX_W-1:0]    pos_i,
  input  logic                inv_i,
  output logic                bit_o
);
  logic [MAX_BITS-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (start_i) data_q <= data_i;
  end

  assign bit_o = data_q[pos_i] ^ inv_i;
endmodule

// File: rtl/sse_rx.sv
module sse_rx #(
  parameter int MAX_BITS = 16,
  parameter int IDX_W    = 4,
  parameter int NB_W     = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                sample_i,
  input  logic                last_i,
  input  logic [IDX_W-1:0]    pos_i,
  input  logic                bit_i,
  input  logic                inv_i,
  input  logic [NB_W-1:0]     nbits_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o
);
  logic [MAX_BITS-1:0] shreg_q, shreg_nxt;

  always_comb begin
    shreg_nxt        = shreg_q;
    shreg_nxt[pos_i] = bit_i ^ inv_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        shreg_q <= '0;
      end else if (sample_i) begin
        shreg_q <= shreg_nxt;
        if (last_i) begin
          data_o  <= shreg_nxt;
          valid_o <= 1'b1;
        end
      end
    end
  end

  p_rx_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_rx_upper_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o >> nbits_i) == '0));
endmodule

// File: rtl/sync_shift_engine.sv
module sync_shift_engine #(
  parameter int MAX_BITS = 16,
  parameter int INT_W    = 13,
  parameter int FRAC_W   = 2,
  localparam int DIV_W   = INT_W + FRAC_W,
  localparam int NB_W    = $clog2(MAX_BITS + 1),
  localparam int IDX_W   = $clog2(MAX_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DIV_W-1:0]    div_i,
  input  logic [NB_W-1:0]     nbits_i,
  input  logic                msb_first_i,
  input  logic                tx_inv_i,
  input  logic                rx_inv_i,
  input  logic                loopback_i,
  input  logic [MAX_BITS-1:0] tx_data_i,
  input  logic                tx_valid_i,
  output logic                tx_ready_o,
  output logic [MAX_BITS-1:0] rx_data_o,
  output logic                rx_valid_o,
  output logic                sclk_o,
  output logic                sdo_o,
  input  logic                sdi_i
);
  import sse_pkg::*;

  logic             busy_q, sclk_q;
  logic [IDX_W-1:0] idx_q, pos, last_idx;
  logic [NB_W-1:0]  nb_q, nb_eff;
  sse_mode_t        mode_q;
  logic             start, tick, rise_tick, fall_tick, at_last;
  logic             tx_bit, rx_in;

  always_comb begin
    if (nbits_i < NB_W'(SSE_MIN_BITS))  nb_eff = NB_W'(SSE_MIN_BITS);
    else if (nbits_i > NB_W'(MAX_BITS)) nb_eff = NB_W'(MAX_BITS);
    else                                nb_eff = nbits_i;
  end

  assign start     = tx_valid_i && !busy_q;
  assign rise_tick = tick && !sclk_q;
  assign fall_tick = tick && sclk_q;
  assign last_idx  = IDX_W'(nb_q - NB_W'(1));
  assign at_last   = (idx_q == last_idx);
  assign pos       = mode_q.msb_first ? (last_idx - idx_q) : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      idx_q  <= '0;
      nb_q   <= NB_W'(SSE_MIN_BITS);
      mode_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      idx_q  <= '0;
      nb_q   <= nb_eff;
      mode_q <= '{msb_first: msb_first_i, tx_inv: tx_inv_i, rx_inv: rx_inv_i};
    end else if (busy_q && tick) begin
      sclk_q <= ~sclk_q;
      if (fall_tick) begin
        if (at_last) busy_q <= 1'b0;
        else         idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  sse_clkgen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_clkgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .run_i   (busy_q),
    .div_i   (div_i),
    .tick_o  (tick)
  );

  sse_tx #(.MAX_BITS(MAX_BITS), .IDX_W(IDX_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .data_i  (tx_data_i),
    .pos_i   (pos),
    .inv_i   (mode_q.tx_inv),
    .bit_o   (tx_bit)
  );

  assign sdo_o = busy_q ? tx_bit : tx_inv_i;
  assign rx_in = loopback_i ? sdo_o : sdi_i;

  sse_rx #(.MAX_BITS(MAX_BITS), .IDX_W(IDX_W), .NB_W(NB_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .sample_i (rise_tick),
    .last_i   (at_last),
    .pos_i    (pos),
    .bit_i    (rx_in),
    .inv_i    (mode_q.rx_inv),
    .nbits_i  (nb_q),
    .data_o   (rx_data_o),
    .valid_o  (rx_valid_o)
  );

  assign sclk_o     = sclk_q;
  assign tx_ready_o = !busy_q;

  p_idle_sclk_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> !sclk_o);
  p_accept_drops_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);
  p_sdo_hold_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && sclk_o && $past(sclk_o)) |-> $stable(sdo_o));
endmodule

// File: tb/tb_sync_shift_engine.sv
module tb_sync_shift_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] div_i = '0;
  logic [4:0]  nbits_i = 5'd8;
  logic        msb_first_i = 1'b0, tx_inv_i = 1'b0, rx_inv_i = 1'b0, loopback_i = 1'b1;
  logic [15:0] tx_data_i = '0;
  logic        tx_valid_i = 1'b0;
  logic        tx_ready_o, rx_valid_o, sclk_o, sdo_o;
  logic [15:0] rx_data_o;
  logic        sdi_i = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  sync_shift_engine dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .nbits_i(nbits_i),
    .msb_first_i(msb_first_i), .tx_inv_i(tx_inv_i), .rx_inv_i(rx_inv_i),
    .loopback_i(loopback_i), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one frame with full checking at the pins
  task automatic run_frame(input string tag, input logic [15:0] data, input int nb,
                           input bit msb, input bit tinv, input bit rinv, input bit lb,
                           input int ii, input int ff, input bit sdi_v);
    int n, busy, rises, got_rx, guard, exp_busy;
    logic [15:0] wire_w, exp_w, rxd, exp_rx, mask;
    logic prev_sclk, prev_sdo;
    bit stable_ok;
    n = (nb < 4) ? 4 : ((nb > 16) ? 16 : nb);
    mask = 16'((32'h1 << n) - 1);
    @(negedge clk_i);
    div_i = {ii[12:0], ff[1:0]};
    nbits_i = nb[4:0]; msb_first_i = msb; tx_inv_i = tinv; rx_inv_i = rinv;
    loopback_i = lb; sdi_i = sdi_v; tx_data_i = data; tx_valid_i = 1'b1;
    @(negedge clk_i);
    tx_valid_i = 1'b0;
    busy = 0; rises = 0; got_rx = 0; guard = 0; stable_ok = 1'b1;
    wire_w = '0; rxd = '0; prev_sclk = 1'b0; prev_sdo = sdo_o;
    while (!tx_ready_o && guard < 20000) begin
      busy++; guard++;
      if (sclk_o && !prev_sclk) begin
        if (rises < 16) wire_w[rises] = sdo_o;
        rises++;
      end
      if (sclk_o && prev_sclk && sdo_o != prev_sdo) stable_ok = 1'b0;
      if (rx_valid_o) begin got_rx++; rxd = rx_data_o; end
      prev_sclk = sclk_o; prev_sdo = sdo_o;
      @(negedge clk_i);
    end
    exp_busy = 2 * n * (ii + 1) + (2 * n * ff) / 4;
    exp_w = '0;
    for (int k = 0; k < n; k++) exp_w[k] = (msb ? data[n-1-k] : data[k]) ^ tinv;
    if (lb) exp_rx = (data ^ ((tinv ^ rinv) ? 16'hFFFF : 16'h0)) & mask;
    else    exp_rx = ((sdi_v ^ rinv) ? 16'hFFFF : 16'h0) & mask;
    chk(busy == exp_busy, {tag, " R6 frame length"}, busy, exp_busy);
    chk(rises == n, {tag, " R1 R2 clock edges"}, rises, n);
    chk(wire_w == exp_w, {tag, " R3 R4 wire bits"}, wire_w, exp_w);
    chk(stable_ok, {tag, " R7 data held while clock high"}, stable_ok, 1);
    chk(got_rx == 1, {tag, " R9 single strobe"}, got_rx, 1);
    chk(rxd == exp_rx, {tag, " R5 R9 R10 received word"}, rxd, exp_rx);
    chk(sdo_o == tx_inv_i && !sclk_o, {tag, " R4 R8 idle levels"}, {sdo_o, sclk_o}, {tx_inv_i, 1'b0});
  endtask

  task automatic t_reset();
    chk(tx_ready_o == 1'b1, "R8 reset ready", tx_ready_o, 1);
    chk(sclk_o == 1'b0, "R8 reset sclk", sclk_o, 0);
    chk(rx_valid_o == 1'b0, "R9 reset strobe", rx_valid_o, 0);
    chk(sdo_o == 1'b0, "R4 reset sdo", sdo_o, 0);
  endtask

  task automatic t_order();
    run_frame("lsb8", 16'h00A7, 8, 0, 0, 0, 1, 0, 0, 0);
    run_frame("msb8", 16'h00A7, 8, 1, 0, 0, 1, 1, 0, 0);
    run_frame("msb12", 16'h0C35, 12, 1, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_lengths();
    run_frame("len4", 16'hFFF9, 4, 0, 0, 0, 1, 0, 0, 0);
    run_frame("len16", 16'hB38E, 16, 1, 0, 0, 1, 0, 0, 0);
    run_frame("clamp_lo", 16'h00F6, 2, 0, 0, 0, 1, 0, 0, 0);
    run_frame("clamp_hi", 16'h5A3C, 20, 0, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_invert();
    run_frame("inv_both", 16'h0123, 10, 0, 1, 1, 1, 0, 0, 0);
    run_frame("inv_tx", 16'h0123, 10, 0, 1, 0, 1, 0, 0, 0);
    run_frame("inv_rx", 16'h0123, 10, 1, 0, 1, 1, 0, 0, 0);
  endtask

  task automatic t_external();
    run_frame("ext_hi", 16'h0000, 7, 0, 0, 0, 0, 0, 0, 1);
    run_frame("ext_lo_inv", 16'h1234, 9, 0, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_fraction();
    run_frame("div2.00", 16'h0055, 6, 0, 0, 0, 1, 2, 0, 0);
    run_frame("div1.25", 16'h0055, 6, 0, 0, 0, 1, 1, 1, 0);
    run_frame("div0.50", 16'h0155, 9, 1, 0, 0, 1, 0, 2, 0);
    run_frame("div3.75", 16'h002D, 5, 0, 0, 0, 1, 3, 3, 0);
  endtask

  task automatic t_back_to_back();
    // valid held high: ready must drop on the cycle after acceptance
    @(negedge clk_i);
    div_i = '0; nbits_i = 5'd4; loopback_i = 1'b1; tx_inv_i = 1'b0; rx_inv_i = 1'b0;
    tx_data_i = 16'h0006; tx_valid_i = 1'b1;
    @(negedge clk_i);
    chk(tx_ready_o == 1'b0, "R8 ready drops after accept", tx_ready_o, 0);
    tx_valid_i = 1'b0;
    while (!tx_ready_o) @(negedge clk_i);
    chk(rx_data_o == 16'h0006, "R10 back-to-back word", rx_data_o, 16'h0006);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_order();
    t_lengths();
    t_invert();
    t_external();
    t_fraction();
    t_back_to_back();
    repeat (4) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule